// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output. An 8-bit timer is stepped through a selectable prescaler and extended below by two sub-count bits, which gives a 10-bit time base. An 8-bit period value sets the point where the timer wraps. A 10-bit duty value sets the point in each period where the output falls.

Software writes the duty value into a master register pair at any time. The pair is copied into a slave register only when a period ends, so a new duty takes effect at a period boundary and never inside a period. A read port shows the slave value at all times.

Writes go through a small register port. The period goes to one address and the upper eight duty bits to a second. A control byte at a third address holds the two low duty bits, the prescale select and the enable bit.

Top module: `pwm_dbuf`

## Requirements
- R1: A write at address 0 loads the period, a write at address 1 loads duty bits [9:2], and a write at address 2 loads the control byte. In that byte, bits [1:0] are duty bits [1:0], bits [3:2] are the prescale select and bit 4 is the enable. `duty_live` always shows the slave duty value.
- R2: Prescale select 0 steps the time base once per clock, 1 once per 4 clocks, and 2 or 3 once per 16 clocks. One PWM period lasts (period + 1) × 4 × prescale clocks, and the output rises on the first clock of each period when the duty is nonzero.
- R3: For a duty D with 0 < D ≤ 4 × period + 3, the output is high for exactly D × prescale clocks in each period.
- R4: For a duty of zero, the output stays low for the whole period.
- R5: For a duty above 4 × period + 3, the output stays high for the whole period and does not fall between periods.
- R6: A duty write changes neither the output nor `duty_live` before the end of the current period. At that end, the slave duty takes the master value, and the following period uses it.
- R7: While the enable bit is 0, the output is low from the second clock after the disabling write, and the timer, prescaler and sub-count bits are held at zero. After the block is enabled, the output stays low for one full period and then rises.
- R8: After reset, the output is low, `duty_live` is 0 and the block is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 period, 1 duty high, 2 control |
| wr_data | input | 8 | Register write data |
| duty_live | output | 10 | Slave duty value in effect for the current period |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume three things about the inputs. The period and the prescale select change only while the block is disabled. The two parts of a duty value are not split across a period boundary. The time base reaches zero only at a rollover. The stimulus follows all three rules. It disables the block before each new period and prescale setting, it enables the block in the same write that carries the low duty bits, and it writes a new upper duty byte two clocks after a period boundary. Random periods, prescale selects and duty values, including zero and values beyond the full count, are mixed with directed cases at the exact full-count boundary and at the largest period.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   typedef enum logic [1:0] {
      REG_PERIOD  = 2'd0,
      REG_DUTY_HI = 2'd1,
      REG_CTRL    = 2'd2
   } reg_addr_e;

   // Right shift applied to the sub-counter for one prescale select value.
   function automatic int unsigned pre_shift(input int unsigned sel,
                                             input int unsigned step,
                                             input int unsigned cap);
      int unsigned s;
      s = sel * step;
      return (s > cap) ? cap : s;
   endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_dbuf_pkg::*;
#(
   parameter int PER_W  = 8,
   parameter int FRAC_W = 2,
   parameter int PSEL_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_addr,
   input  logic [PER_W-1:0]        wr_data,
   output logic [PER_W-1:0]        period_o,
   output logic [PER_W+FRAC_W-1:0] duty_o,
   output logic [PSEL_W-1:0]       psel_o,
   output logic                    run_o
);
   localparam int CTL_W  = FRAC_W + PSEL_W + 1;
   localparam int EN_BIT = FRAC_W + PSEL_W;

   logic [PER_W-1:0]  period_q;
   logic [PER_W-1:0]  duty_hi_q;
   logic [FRAC_W-1:0] duty_lo_q;
   logic [PSEL_W-1:0] psel_q;
   logic              run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q  <= '0;
         duty_hi_q <= '0;
         duty_lo_q <= '0;
         psel_q    <= '0;
         run_q     <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == REG_PERIOD)  period_q  <= wr_data;
         if (wr_addr == REG_DUTY_HI) duty_hi_q <= wr_data;
         if (wr_addr == REG_CTRL) begin
            duty_lo_q <= wr_data[FRAC_W-1:0];
            psel_q    <= wr_data[FRAC_W +: PSEL_W];
            run_q     <= wr_data[EN_BIT];
         end
      end
   end

   generate
      if (CTL_W < PER_W) begin : g_spare
         logic unused_ctl_bits;
         assign unused_ctl_bits = ^wr_data[PER_W-1:CTL_W];
      end
   endgenerate

   assign period_o = period_q;
   assign duty_o   = {duty_hi_q, duty_lo_q};
   assign psel_o   = psel_q;
   assign run_o    = run_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_dbuf_pkg::*;
#(
   parameter int PER_W         = 8,
   parameter int FRAC_W        = 2,
   parameter int PSEL_W        = 2,
   parameter int PRE_STEP      = 2,
   parameter int PRE_SHIFT_MAX = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [PER_W-1:0]        period,
   input  logic [PSEL_W-1:0]       psel,
   output logic                    roll_o,
   output logic [PER_W+FRAC_W-1:0] tb_nx_o
);
   localparam int SUB_W  = FRAC_W + PRE_SHIFT_MAX;
   localparam int N_SEL  = 1 << PSEL_W;
   localparam int SH_W   = $clog2(PRE_SHIFT_MAX + 1);

   logic [SH_W-1:0]  shift_tab [N_SEL];
   logic [SUB_W-1:0] mask_tab  [N_SEL];

   // One shift and one wrap mask per select value.
   generate
      for (genvar s = 0; s < N_SEL; s++) begin : g_sel
         localparam int SH = int'(pre_shift(s, PRE_STEP, PRE_SHIFT_MAX));
         assign shift_tab[s] = SH_W'(SH);
         assign mask_tab[s]  = {SUB_W{1'b1}} >> (PRE_SHIFT_MAX - SH);
      end
   endgenerate

   logic [SUB_W-1:0] sub_q, sub_nx, sub_sh;
   logic [PER_W-1:0] tmr_q, tmr_nx;
   logic [SH_W-1:0]  shift_sel;
   logic [SUB_W-1:0] mask_sel;
   logic             sub_wrap, roll;

   assign shift_sel = shift_tab[psel];
   assign mask_sel  = mask_tab[psel];
   assign sub_wrap  = (sub_q & mask_sel) == mask_sel;
   assign roll      = run && sub_wrap && (tmr_q == period);

   always_comb begin
      if (!run) begin
         sub_nx = '0;
         tmr_nx = '0;
      end else begin
         sub_nx = sub_wrap ? '0 : sub_q + SUB_W'(1);
         if (roll)
            tmr_nx = '0;
         else if (sub_wrap)
            tmr_nx = tmr_q + PER_W'(1);
         else
            tmr_nx = tmr_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         tmr_q <= '0;
      end else begin
         sub_q <= sub_nx;
         tmr_q <= tmr_nx;
      end
   end

   assign sub_sh  = sub_nx >> shift_sel;
   assign roll_o  = roll;
   assign tb_nx_o = {tmr_nx, sub_sh[FRAC_W-1:0]};

   // R2: the timer moves only when the sub-count wraps
   a_r2_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !sub_wrap) |=> $stable(tmr_q));

   // R7: a disabled block restarts its time base from zero
   a_r7_base_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sub_q == '0 && tmr_q == '0));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              roll,
   input  logic [DUTY_W-1:0] tb_nx,
   input  logic [DUTY_W-1:0] master,
   output logic [DUTY_W-1:0] slave_o,
   output logic              pwm_o
);
   logic [DUTY_W-1:0] slave_q;
   logic              pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_q <= '0;
         pwm_q   <= 1'b0;
      end else if (!run) begin
         pwm_q <= 1'b0;
      end else if (roll) begin
         slave_q <= master;
         pwm_q   <= |master;
      end else if (tb_nx == slave_q) begin
         pwm_q <= 1'b0;
      end
   end

   assign slave_o = slave_q;
   assign pwm_o   = pwm_q;

   // R6: the slave copy changes only at a rollover
   a_r6_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !roll |=> $stable(slave_q));

   // R4: a rising output needs a rollover with a nonzero duty
   a_r4_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q) |-> ($past(roll) && ($past(master) != '0)));

   // R3: the output falls once the time base reaches the slave duty
   a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !roll && (tb_nx == slave_q)) |=> !pwm_q);

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
   parameter int PER_W         = 8,
   parameter int FRAC_W        = 2,
   parameter int PSEL_W        = 2,
   parameter int PRE_STEP      = 2,
   parameter int PRE_SHIFT_MAX = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_addr,
   input  logic [PER_W-1:0]        wr_data,
   output logic [PER_W+FRAC_W-1:0] duty_live,
   output logic                    pwm_o
);
   localparam int DUTY_W = PER_W + FRAC_W;

   generate
      if (PER_W < FRAC_W + PSEL_W + 1) begin : g_bad_width
         $error("pwm_dbuf: PER_W too narrow for the control byte");
      end
      if (FRAC_W < 1 || PSEL_W < 1) begin : g_bad_field
         $error("pwm_dbuf: FRAC_W and PSEL_W must be at least 1");
      end
      if (PRE_STEP < 1 || PRE_SHIFT_MAX < PRE_STEP) begin : g_bad_pre
         $error("pwm_dbuf: prescale step and cap are inconsistent");
      end
   endgenerate

   logic [PER_W-1:0]  period;
   logic [DUTY_W-1:0] duty_master;
   logic [PSEL_W-1:0] psel;
   logic              run;
   logic              roll;
   logic [DUTY_W-1:0] tb_nx;

   pwm_regs #(.PER_W(PER_W), .FRAC_W(FRAC_W), .PSEL_W(PSEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .period_o (period),
      .duty_o   (duty_master),
      .psel_o   (psel),
      .run_o    (run)
   );

   pwm_timebase #(
      .PER_W(PER_W), .FRAC_W(FRAC_W), .PSEL_W(PSEL_W),
      .PRE_STEP(PRE_STEP), .PRE_SHIFT_MAX(PRE_SHIFT_MAX)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .period  (period),
      .psel    (psel),
      .roll_o  (roll),
      .tb_nx_o (tb_nx)
   );

   pwm_duty_latch #(.DUTY_W(DUTY_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .roll    (roll),
      .tb_nx   (tb_nx),
      .master  (duty_master),
      .slave_o (duty_live),
      .pwm_o   (pwm_o)
   );

   // R7: output low one clock after the enable is seen low
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm_o);

endmodule

// File: tb/sim_pwm_dbuf.sv
`timescale 1ns/1ps
module sim_pwm_dbuf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [9:0] duty_live;
   logic       pwm_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .duty_live(duty_live), .pwm_o(pwm_o)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 190000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all reqs) actual=%0d expected=<190000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int pre_of(input int sel);
      return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
   endfunction

   function automatic int exp_hi(input int d, input int pr, input int p);
      if (d == 0) return 0;
      if (d > 4 * pr + 3) return (pr + 1) * 4 * p;
      return d * p;
   endfunction

   function automatic string tag_of(input int d, input int pr);
      if (d == 0) return "R4";
      if (d > 4 * pr + 3) return "R5";
      return "R3";
   endfunction

   task automatic run_case(input int pr, input int sel, input int d, input int d2msb);
      int p, n, d2, hi1, hi2, hi3;
      p  = pre_of(sel);
      n  = (pr + 1) * 4 * p;
      d2 = d2msb * 4 + (d % 4);
      hi1 = 0; hi2 = 0; hi3 = 0;
      wr(2, 0);
      @(negedge clk);
      chk(pwm_o == 1'b0, "R7 disabled", int'(pwm_o), 0);
      wr(0, pr);
      wr(1, d >> 2);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'((1 << 4) | (sel << 2) | (d % 4));
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < 3 * n; i++) begin
         if (i > 0) @(negedge clk);
         if (i == n + 1) begin
            wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'(d2msb);
         end else begin
            wr_en = 1'b0;
         end
         if (i == n) begin
            chk(pwm_o == (d != 0), "R2 rise at period start", int'(pwm_o), int'(d != 0));
            chk(duty_live == 10'(d), "R1 duty readback", int'(duty_live), d);
         end
         if (i == n + 2)
            chk(duty_live == 10'(d), "R6 slave held", int'(duty_live), d);
         if (i == 2 * n)
            chk(duty_live == 10'(d2), "R6 slave update", int'(duty_live), d2);
         if (i < n) hi1 += int'(pwm_o);
         else if (i < 2 * n) hi2 += int'(pwm_o);
         else hi3 += int'(pwm_o);
      end
      wr_en = 1'b0;
      chk(hi1 == 0, "R7 first period low", hi1, 0);
      chk(hi2 == exp_hi(d, pr, p), tag_of(d, pr), hi2, exp_hi(d, pr, p));
      chk(hi3 == exp_hi(d2, pr, p), "R6 new duty used", hi3, exp_hi(d2, pr, p));
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_o == 1'b0, "R8 reset output", int'(pwm_o), 0);
      chk(duty_live == '0, "R8 reset duty", int'(duty_live), 0);
      // directed corners
      run_case(3, 0, 0, 5);
      run_case(3, 0, 15, 4);
      run_case(3, 0, 16, 0);
      run_case(0, 0, 3, 0);
      run_case(0, 3, 4, 0);
      run_case(2, 1, 7, 2);
      run_case(255, 0, 1023, 0);
      run_case(5, 2, 1, 6);
      // random mix
      for (int k = 0; k < 16; k++) begin
         int pr, sel, d, m;
         pr  = int'($urandom % 24);
         sel = int'($urandom % 4);
         d   = int'($urandom % (4 * pr + 8));
         m   = int'($urandom % (pr + 3));
         run_case(pr, sel, d, m);
      end
      wr(2, 0);
      @(negedge clk);
      chk(pwm_o == 1'b0, "R7 final disable", int'(pwm_o), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule